// File: doc/BRIEF.md
# External Bus Wait-State and READY Handshake Controller

This block runs one read or write transfer at a time on a demultiplexed external bus on behalf of an internal master. A transfer is requested through a simple request/acknowledge port carrying an address, a write flag and write data. The block then drives an address-latch phase and asserts the read or write strobe. It holds that strobe for a programmed number of fixed wait states. When handshaking is switched on, it keeps holding the strobe until an external READY line reports the device as finished.

READY can be taken either straight off the bus clock (synchronous, fastest) or through a two-flop synchronizer (asynchronous, safe for unclocked devices but slower). The bus clock is driven out so that external logic can time a synchronous READY against it. The active level of READY is selectable. There is no time-out. A device that never signals READY freezes the transfer, and only reset recovers it. The configuration inputs are captured when a request is accepted and hold for the whole transfer.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: While reset is low, and in the first state after it, `bus_ale` is 0, `bus_rd_n` and `bus_wr_n` are 1, `bus_doe` is 0 and `ack` is 0.
- R2: An accepted request gives exactly one state with `bus_ale` = 1 and `bus_addr` equal to the request address. The strobe follows in the next state: `bus_rd_n` = 0 when `req_we` = 0, and `bus_wr_n` = 0 when `req_we` = 1. ALE and a strobe are never active together, and the two strobes are never active together.
- R3: The programmed wait states (`cfg_waits`, 0..15) always run first. With `cfg_rdy_en` = 0 the strobe stays active for exactly `cfg_waits` + 1 states.
- R4: In synchronous mode (`cfg_rdy_en` = 1, `cfg_rdy_async` = 0), READY is evaluated in strobe state n for every n >= `cfg_waits` + 1. The value used is the pin level in that same state. The strobe ends after the first such state in which READY is active. If READY turns active in strobe state D and stays active, the strobe length is max(`cfg_waits` + 1, D).
- R5: In asynchronous mode (`cfg_rdy_async` = 1) one extra wait state is inserted. READY is evaluated in strobe states n >= `cfg_waits` + 2, using the pin level of state n - 2, where state 0 is the ALE state. If READY turns active in strobe state D and stays active, the strobe length is max(`cfg_waits` + 2, D + 2).
- R6: `cfg_rdy_pol` = 1 makes READY active high. `cfg_rdy_pol` = 0 makes it active low.
- R7: With handshaking on and READY never active, the strobe stays asserted and `ack` never rises. A reset returns the bus to idle, and later transfers work normally.
- R8: In the state after the last strobe state, the strobe is released and `ack` is 1 for that one state only. For a read, `rdata` then holds the `bus_din` value present in the last strobe state.
- R9: During the strobe states of a write, `bus_doe` is 1 and `bus_dout` equals the request write data. `bus_doe` is 0 at all other times.
- R10: Configuration inputs are captured when a request is accepted. Changes made to them during the transfer have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus state clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Transfer request, sampled while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| ack | output | 1 | One-state completion pulse |
| rdata | output | DATA_W | Captured read data |
| cfg_waits | input | WAIT_W | Fixed wait-state count |
| cfg_rdy_en | input | 1 | Enable READY handshake |
| cfg_rdy_async | input | 1 | 1 = synchronized READY path |
| cfg_rdy_pol | input | 1 | 1 = READY active high |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | ADDR_W | External address |
| bus_dout | output | DATA_W | External write data |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | DATA_W | External read data |
| bus_clkout | output | 1 | Bus clock driven out |
| bus_ready | input | 1 | External READY line |

## Verification
The checker watches the phase ordering on every cycle. It confirms that ALE never overlaps a strobe, that ALE is followed by a strobe, that the read and write strobes are mutually exclusive, that `ack` is a single pulse that coincides with strobe release, that write data is only enabled under the write strobe, and that the bus is idle after reset. Strobe lengths depend on the wait count, the READY mode, the polarity and the moment READY turns active. So do read data capture, insensitivity to configuration changes mid-transfer, and the indefinite stall with recovery by reset. These can only be shown by the bench's scenarios, which model an external device and compare measured strobe lengths against the formulas.

// File: rtl/xbw_pkg.sv
// Package: shared types for the external bus wait controller.
// Assumes one transfer in flight at a time.
package xbw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_WAIT = 3'd2,
        ST_EVAL = 3'd3,
        ST_DONE = 3'd4
    } bus_state_t;
endpackage

// File: rtl/xbw_ready_path.sv
// Module: READY qualifier. Produces an "active" indication either directly
// from the pin (synchronous mode) or from a SYNC_DEPTH flop chain
// (asynchronous mode), then applies the selected polarity.
// Assumes the pin is stable around clk edges in synchronous mode.
module xbw_ready_path #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic async_sel,
    input  logic pol_high,
    output logic ready_ok
);
    logic [SYNC_DEPTH-1:0] sync_q;
    logic                  raw;

    generate
        for (genvar i = 0; i < SYNC_DEPTH; i++) begin : g_sync
            if (i == 0) begin : g_first
                // first synchronizer stage samples the pin
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pin;
                end
            end else begin : g_next
                // later stages shift the sample along
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    // select path and fold in polarity
    always_comb begin
        raw      = async_sel ? sync_q[SYNC_DEPTH-1] : pin;
        ready_ok = pol_high ? raw : ~raw;
    end
endmodule

// File: rtl/xbw_wait_count.sv
// Module: wait-state down counter. Loaded with the effective wait count in
// the address state, decremented in each wait state; flags the last one.
// Assumes the controller never decrements a zero count.
module xbw_wait_count #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    // load or count down
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    // last wait state when one remains
    always_comb last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/xbw_cycle_fsm.sv
// Module: transfer sequencer. Accepts a request while idle, latches it with
// the configuration, and steps ALE -> wait states -> READY evaluation ->
// release/acknowledge. Bus outputs are decoded from the state register.
// Assumes the requester keeps req low after ack until it wants another cycle.
module xbw_cycle_fsm
    import xbw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int WAIT_W = 4,
    localparam int CNT_W = WAIT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WAIT_W-1:0] cfg_waits,
    input  logic              cfg_rdy_en,
    input  logic              cfg_rdy_async,
    input  logic              cfg_rdy_pol,
    input  logic              ready_ok,
    input  logic              cnt_last,
    input  logic [DATA_W-1:0] bus_din,
    output logic              cnt_load,
    output logic              cnt_dec,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              async_q,
    output logic              pol_q,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe
);
    bus_state_t        state_q;
    logic              we_q;
    logic              en_q;
    logic [WAIT_W-1:0] waits_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              strobe;
    logic              finish;

    // effective wait count: async path costs one extra state
    always_comb cnt_val = {1'b0, waits_q} + CNT_W'(en_q & async_q);

    // counter control and the end-of-evaluation condition
    always_comb begin
        cnt_load = (state_q == ST_ADDR);
        cnt_dec  = (state_q == ST_WAIT);
        finish   = (state_q == ST_EVAL) && (!en_q || ready_ok);
    end

    // state register plus request and configuration capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            we_q    <= 1'b0;
            en_q    <= 1'b0;
            async_q <= 1'b0;
            pol_q   <= 1'b1;
            waits_q <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req) begin
                    we_q    <= req_we;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    waits_q <= cfg_waits;
                    en_q    <= cfg_rdy_en;
                    async_q <= cfg_rdy_async;
                    pol_q   <= cfg_rdy_pol;
                    state_q <= ST_ADDR;
                end
                ST_ADDR: state_q <= (cnt_val == '0) ? ST_EVAL : ST_WAIT;
                ST_WAIT: if (cnt_last) state_q <= ST_EVAL;
                ST_EVAL: if (finish) begin
                    if (!we_q) rdata_q <= bus_din;
                    state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // bus pin decode from the state
    always_comb begin
        strobe   = (state_q == ST_WAIT) || (state_q == ST_EVAL);
        bus_ale  = (state_q == ST_ADDR);
        bus_rd_n = !(strobe && !we_q);
        bus_wr_n = !(strobe && we_q);
        bus_doe  = strobe && we_q;
        bus_addr = addr_q;
        bus_dout = wdata_q;
        ack      = (state_q == ST_DONE);
        rdata    = rdata_q;
    end
endmodule

// File: rtl/xbus_wait_ctrl.sv
// Module: top of the external bus wait controller. Ties the sequencer,
// wait counter and READY qualifier together and drives the bus clock out.
// Assumes a single address window whose configuration is on the cfg_* pins.
module xbus_wait_ctrl #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int WAIT_W     = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    input  logic [WAIT_W-1:0] cfg_waits,
    input  logic              cfg_rdy_en,
    input  logic              cfg_rdy_async,
    input  logic              cfg_rdy_pol,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_clkout,
    input  logic              bus_ready
);
    localparam int CNT_W = WAIT_W + 1;

    logic             ready_ok;
    logic             cnt_last;
    logic             cnt_load;
    logic             cnt_dec;
    logic [CNT_W-1:0] cnt_val;
    logic             async_q;
    logic             pol_q;

    // bus clock is the state clock
    assign bus_clkout = clk;

    xbw_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_waits(cfg_waits), .cfg_rdy_en(cfg_rdy_en),
        .cfg_rdy_async(cfg_rdy_async), .cfg_rdy_pol(cfg_rdy_pol),
        .ready_ok(ready_ok), .cnt_last(cnt_last), .bus_din(bus_din),
        .cnt_load(cnt_load), .cnt_dec(cnt_dec), .cnt_val(cnt_val),
        .async_q(async_q), .pol_q(pol_q),
        .ack(ack), .rdata(rdata),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe)
    );

    xbw_wait_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
        .dec(cnt_dec), .last(cnt_last)
    );

    xbw_ready_path #(.SYNC_DEPTH(SYNC_DEPTH)) u_rdy (
        .clk(clk), .rst_n(rst_n), .pin(bus_ready), .async_sel(async_q),
        .pol_high(pol_q), .ready_ok(ready_ok)
    );
endmodule

// File: rtl/xbus_wait_ctrl_chk.sv
// Module: protocol checker for xbus_wait_ctrl, attached by bind.
// Observes only the top-level ports.
module xbus_wait_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ack,
    input logic bus_ale,
    input logic bus_rd_n,
    input logic bus_wr_n,
    input logic bus_doe
);
    logic strobe_on;
    logic rst_low_q;

    always_comb strobe_on = !bus_rd_n || !bus_wr_n;

    // remembers that the previous edge saw reset low
    always_ff @(posedge clk) rst_low_q <= !rst_n;

    // R1: idle bus right after a reset edge
    always @(posedge clk) begin
        if (rst_low_q === 1'b1) begin
            assert_reset_idle_R1: assert (!bus_ale && bus_rd_n && bus_wr_n && !bus_doe && !ack)
                else $error("R1 bus not idle after reset");
        end
    end

    assert_ale_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ale && strobe_on));

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    assert_ale_then_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> strobe_on);

    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_ack_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (!strobe_on && $past(strobe_on)));

    assert_release_acks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_on) |-> ack);

    assert_doe_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> !bus_wr_n);
endmodule

bind xbus_wait_ctrl xbus_wait_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .bus_ale(bus_ale),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_doe(bus_doe)
);

// File: tb/xbus_wait_ctrl_bench.sv
`timescale 1ns/1ps
module xbus_wait_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [3:0]  cfg_waits = '0;
    logic        cfg_rdy_en = 1'b0;
    logic        cfg_rdy_async = 1'b0;
    logic        cfg_rdy_pol = 1'b1;
    logic        bus_ale, bus_rd_n, bus_wr_n, bus_doe, bus_clkout;
    logic [15:0] bus_addr, bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_ready = 1'b0;

    int checks = 0;
    int fails = 0;

    // device model state
    int          m_cnt = 0;
    int          m_dly = 1000;
    bit          m_pol = 1'b1;
    logic [15:0] m_base = 16'h0;
    int          meas = 0;

    always #2.5 clk = ~clk;

    xbus_wait_ctrl u_xbus_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .cfg_waits(cfg_waits), .cfg_rdy_en(cfg_rdy_en),
        .cfg_rdy_async(cfg_rdy_async), .cfg_rdy_pol(cfg_rdy_pol),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_clkout(bus_clkout), .bus_ready(bus_ready)
    );

    // external device: counts strobe states, raises READY from state m_dly on
    always @(negedge clk) begin
        bit act;
        if (!bus_rd_n || !bus_wr_n) begin
            m_cnt = m_cnt + 1;
        end else begin
            if (ack) meas = m_cnt;
            m_cnt = 0;
        end
        act = (m_cnt > 0) && (m_cnt >= m_dly);
        bus_ready = m_pol ? act : !act;
        bus_din = m_base + 16'(m_cnt);
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        req = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!bus_ale && bus_rd_n && bus_wr_n && !bus_doe && !ack, "R1", "idle in reset",
              {bus_ale, bus_rd_n, bus_wr_n, bus_doe, ack}, 5'b01100);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_ale && bus_rd_n && bus_wr_n && !ack, "R1", "idle after reset",
              {bus_ale, bus_rd_n, bus_wr_n, ack}, 4'b0110);
    endtask

    // one transfer; checks phases, strobe length, data and ack pulse
    task automatic run_cycle(input bit we, input logic [15:0] a, input logic [15:0] d,
                             input int w, input bit en, input bit asy, input bit pol,
                             input int dly, input int exp_len, input bit scramble,
                             input string rq);
        int ale_n = 0;
        bit addr_bad = 0, saw_rd = 0, saw_wr = 0, dout_bad = 0, got = 0;
        m_pol  = pol;
        m_dly  = en ? dly : 1000;
        m_base = 16'h5A00 + 16'(w * 16);
        @(negedge clk);
        cfg_waits = 4'(w);
        cfg_rdy_en = en;
        cfg_rdy_async = asy;
        cfg_rdy_pol = pol;
        req_we = we;
        req_addr = a;
        req_wdata = d;
        req = 1'b1;
        for (int i = 0; i < 300 && !got; i++) begin
            @(negedge clk);
            if (bus_ale) begin
                ale_n++;
                if (bus_addr !== a) addr_bad = 1;
                req = 1'b0;
                req_addr = ~a;
                req_wdata = ~d;
                if (scramble) begin
                    cfg_waits = 4'hF;
                    cfg_rdy_en = 1'b1;
                    cfg_rdy_async = ~asy;
                end
            end
            if (!bus_rd_n) saw_rd = 1;
            if (!bus_wr_n) begin
                saw_wr = 1;
                if (!bus_doe || bus_dout !== d) dout_bad = 1;
            end
            if (ack) got = 1;
        end
        #1;
        check(got, rq, "ack seen", int'(got), 1);
        check(meas == exp_len, rq, "strobe length", meas, exp_len);
        check(ale_n == 1 && !addr_bad, "R2", "single ALE state with address", ale_n, 1);
        check(we ? (saw_wr && !saw_rd) : (saw_rd && !saw_wr), "R2", "strobe type",
              {saw_rd, saw_wr}, we ? 1 : 2);
        if (we)
            check(!dout_bad, "R9", "write data driven under strobe", int'(dout_bad), 0);
        else
            check(rdata == m_base + 16'(exp_len), "R8", "read data capture",
                  int'(rdata), int'(m_base + 16'(exp_len)));
        @(negedge clk);
        check(!ack && !bus_doe, "R8", "ack single state", {ack, bus_doe}, 0);
        cfg_waits = '0;
        cfg_rdy_en = 1'b0;
        cfg_rdy_async = 1'b0;
    endtask

    task automatic test_stall();
        int acks = 0;
        bit strobe_held = 1;
        m_pol = 1'b1;
        m_dly = 1000;
        @(negedge clk);
        cfg_waits = 4'd2;
        cfg_rdy_en = 1'b1;
        cfg_rdy_async = 1'b0;
        cfg_rdy_pol = 1'b1;
        req_we = 1'b0;
        req_addr = 16'h0777;
        req = 1'b1;
        repeat (2) @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (ack) acks++;
            if (i > 2 && bus_rd_n) strobe_held = 0;
        end
        check(acks == 0, "R7", "no ack without READY", acks, 0);
        check(strobe_held, "R7", "strobe held during stall", int'(strobe_held), 1);
        do_reset();
        run_cycle(1'b0, 16'h0778, 16'h0, 1, 1'b1, 1'b0, 1'b1, 2, 2, 1'b0, "R7");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R3: fixed waits only
        run_cycle(1'b0, 16'h1000, 16'h0, 0, 1'b0, 1'b0, 1'b1, 0, 1, 1'b0, "R3");
        run_cycle(1'b0, 16'h1002, 16'h0, 5, 1'b0, 1'b0, 1'b1, 0, 6, 1'b0, "R3");
        run_cycle(1'b1, 16'h2004, 16'hBEEF, 2, 1'b0, 1'b0, 1'b1, 0, 3, 1'b0, "R9");
        run_cycle(1'b0, 16'h1006, 16'h0, 15, 1'b0, 1'b0, 1'b1, 0, 16, 1'b0, "R3");
        // R4: synchronous READY
        run_cycle(1'b0, 16'h3000, 16'h0, 1, 1'b1, 1'b0, 1'b1, 4, 4, 1'b0, "R4");
        run_cycle(1'b0, 16'h3002, 16'h0, 3, 1'b1, 1'b0, 1'b1, 1, 4, 1'b0, "R4");
        run_cycle(1'b1, 16'h3004, 16'h1234, 0, 1'b1, 1'b0, 1'b1, 1, 1, 1'b0, "R4");
        // R5: asynchronous READY
        run_cycle(1'b0, 16'h4000, 16'h0, 0, 1'b1, 1'b1, 1'b1, 1, 3, 1'b0, "R5");
        run_cycle(1'b0, 16'h4002, 16'h0, 4, 1'b1, 1'b1, 1'b1, 2, 6, 1'b0, "R5");
        run_cycle(1'b1, 16'h4004, 16'h4321, 1, 1'b1, 1'b1, 1'b1, 6, 8, 1'b0, "R5");
        // R6: active-low READY, both paths
        run_cycle(1'b0, 16'h5000, 16'h0, 0, 1'b1, 1'b0, 1'b0, 3, 3, 1'b0, "R6");
        run_cycle(1'b0, 16'h5002, 16'h0, 2, 1'b1, 1'b1, 1'b0, 3, 5, 1'b0, "R6");
        // R10: config changed mid-transfer is ignored
        run_cycle(1'b0, 16'h6000, 16'h0, 2, 1'b0, 1'b0, 1'b1, 0, 3, 1'b1, "R10");
        run_cycle(1'b0, 16'h6002, 16'h0, 1, 1'b1, 1'b0, 1'b1, 3, 3, 1'b1, "R10");
        // R7: stall and recovery
        test_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule